// File: doc/BRIEF.md
# Privilege Entry and Return Sequencer

This block carries out the state changes that move a processor core from user to kernel privilege when a software trap, a page fault or an external interrupt is taken. It also carries out the mirror-image change on a return from the kernel. The core's decode logic raises a request that carries an event kind and, for entries, a vector number. The block then fetches a two-word gate from a descriptor table in memory and decides whether the gate may be used. It switches to the kernel stack supplied by a pair of task-state registers and writes the interrupted context onto that stack, one word per memory transaction. Finally it presents the new privilege level, stack, flags, code selector and instruction pointer for the core to load.

On return, the sequencer reads the five saved words back from the current stack pointer upward. It hands the restored user state to the core and sets privilege level 3. A rejected entry, caused by a gate that is not present or by privilege that is too low, completes with a fault flag. In that case no memory write is made and the new-state outputs are left as they were.

Requests use a valid/ready pair. The sequencer takes a request only while idle, and it captures the snapshot inputs in that same cycle. The memory port is also valid/ready: a command is held with unchanged address, direction and write data until the memory raises ready. Read data is taken on a separate data-valid strobe that may come any number of cycles later. Only one command is outstanding at a time.

Top module: `trap_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle, and a request is taken on `req_valid && req_ready`. `busy` is high from the cycle after acceptance through the final state-load cycle. In the following cycle `busy` is low and `done` pulses high for exactly one cycle.
- R2: For an entry, the gate is read as two words. The handler address is at `idt_base + vector*8` and the control word is at `idt_base + vector*8 + 4`. In the control word, bits [15:0] hold the code selector, bit 16 is the present flag, bits [18:17] hold the gate privilege level, and bit 19 marks a gate that clears the interrupt-enable flag.
- R3: For a software trap (kind 0), the gate is refused when the captured privilege level is numerically greater than the gate privilege level, and it is allowed when it is equal or lower.
- R4: A gate whose present flag is clear is refused for every entry kind. A refused entry ends with `fault` high during the `done` pulse, makes no memory write, and leaves all new-state outputs unchanged.
- R5: An allowed entry starts from `tss_sp` and makes five writes. Each write goes to the stack pointer minus 4 and then leaves the pointer there. The words are written in this order: user stack segment, user stack pointer, user flags, user code segment, user instruction pointer. Segment values are zero-extended to 32 bits.
- R6: After an allowed entry the outputs are: `new_cpl` = 0, `new_ss` = `tss_ss`, `new_sp` = `tss_sp - 20`, `new_cs` = gate selector and `new_ip` = gate handler address. `new_flags` equals the user flags, with bit 9 (interrupt enable) cleared only when gate bit 19 is set.
- R7: Page faults (kind 1) and external interrupts (kind 2) skip the privilege comparison. They are refused only for a non-present gate.
- R8: A return (kind 3) makes no write and no gate read. It reads five words from `cur_sp` upward, each read followed by a +4 step: instruction pointer, code segment, flags, stack pointer, stack segment. It then outputs them with `new_cpl` = 3 and `fault` low.
- R9: A memory command keeps `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. A read completes on `mem_rvalid`. `mem_valid` is never high while the sequencer is idle.
- R10: After reset the outputs are: `busy`, `done`, `fault` and `mem_valid` low, `req_ready` high, `new_cpl` = 0, and every other new-state output zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Event request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 software trap, 1 page fault, 2 external interrupt, 3 return |
| req_vec | input | VEC_W | Gate vector number |
| cur_cpl | input | 2 | Current privilege level snapshot |
| cur_ss | input | 16 | Current stack segment snapshot |
| cur_sp | input | 32 | Current stack pointer snapshot |
| cur_flags | input | 32 | Current flags snapshot |
| cur_cs | input | 16 | Current code segment snapshot |
| cur_ip | input | 32 | Current instruction pointer snapshot |
| idt_base | input | 32 | Descriptor table base address |
| tss_ss | input | 16 | Kernel stack segment from task state |
| tss_sp | input | 32 | Kernel stack pointer from task state |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_we | output | 1 | Command is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Entry refused, valid with `done` |
| new_cpl | output | 2 | Privilege level to load |
| new_ss | output | 16 | Stack segment to load |
| new_sp | output | 32 | Stack pointer to load |
| new_flags | output | 32 | Flags to load |
| new_cs | output | 16 | Code segment to load |
| new_ip | output | 32 | Instruction pointer to load |

## Verification
The assertions rest on three assumptions about the environment:
- the memory raises `mem_rvalid` only after it has accepted a read, and once per read;
- `idt_base`, `tss_sp` and `tss_ss` stay constant while `busy` is high;
- requests carry a legal kind.

The bench models memory so that it raises read data exactly one cycle after accepting a read. It holds the table and task-state inputs fixed for the whole run. Every other entry runs with `mem_ready` stalled three cycles out of four, which exercises the hold rule of the command port. The read model answers only at the expected gate and stack addresses, and returns a marker word anywhere else, so a wrong address shows up in the outputs.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int WORD_W     = 32;
  localparam int SEL_W      = 16;
  localparam int CTX_WORDS  = 5;
  localparam int CNT_W      = $clog2(CTX_WORDS);
  localparam int WORD_BYTES = WORD_W / 8;

  // order of the saved context, index 0 written first
  localparam int CTX_SS = 0;
  localparam int CTX_SP = 1;
  localparam int CTX_FL = 2;
  localparam int CTX_CS = 3;
  localparam int CTX_IP = 4;

  // gate control word fields
  localparam int GB_PRESENT = 16;
  localparam int GB_DPL     = 17;
  localparam int GB_CLR_IE  = 19;

  typedef enum logic [1:0] {
    EV_SOFT   = 2'd0,
    EV_PFAULT = 2'd1,
    EV_EXTINT = 2'd2,
    EV_RETURN = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GRD, S_GWT, S_CHK, S_PSH, S_POP, S_PWT, S_LOAD
  } seq_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] target;
    logic [SEL_W-1:0]  sel;
    logic              present;
    logic [1:0]        dpl;
    logic              clr_ie;
  } gate_t;
endpackage

// File: rtl/trap_gate_dec.sv
module trap_gate_dec
  import trap_pkg::*;
(
  input  logic [WORD_W-1:0] w_target,
  input  logic [WORD_W-1:0] w_ctrl,
  input  ev_kind_e          kind,
  input  logic [1:0]        cpl,
  output gate_t             gate,
  output logic              allow
);
  logic unused_ctrl_hi;

  always_comb begin
    gate.target  = w_target;
    gate.sel     = w_ctrl[SEL_W-1:0];
    gate.present = w_ctrl[GB_PRESENT];
    gate.dpl     = w_ctrl[GB_DPL+1:GB_DPL];
    gate.clr_ie  = w_ctrl[GB_CLR_IE];
  end

  // privilege comparison applies to software traps only
  always_comb begin
    allow = gate.present;
    if (kind == EV_SOFT && cpl > gate.dpl) allow = 1'b0;
  end

  assign unused_ctrl_hi = ^w_ctrl[WORD_W-1:GB_CLR_IE+1];
endmodule

// File: rtl/trap_sp_unit.sv
module trap_sp_unit #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] sp,
  output logic [W-1:0] sp_below
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  assign sp_below = sp - STEP_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= '0;
    else if (load) sp <= load_val;
    else if (dec)  sp <= sp_below;
    else if (inc)  sp <= sp + STEP_V;
  end
endmodule

// File: rtl/trap_ctx_file.sv
module trap_ctx_file #(
  parameter int N = 5,
  parameter int W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snap_we,
  input  logic [N-1:0][W-1:0] snap,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [W-1:0]        wr_data,
  output logic [N-1:0][W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q[g] <= '0;
      else if (snap_we)                        q[g] <= snap[g];
      else if (wr_en && wr_idx == IW'(g))      q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int VEC_W  = 5,
  parameter int IE_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic [1:0]        cur_cpl,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0] cur_flags,
  input  logic [SEL_W-1:0]  cur_cs,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic [WORD_W-1:0] idt_base,
  input  logic [SEL_W-1:0]  tss_ss,
  input  logic [WORD_W-1:0] tss_sp,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        new_cpl,
  output logic [SEL_W-1:0]  new_ss,
  output logic [WORD_W-1:0] new_sp,
  output logic [WORD_W-1:0] new_flags,
  output logic [SEL_W-1:0]  new_cs,
  output logic [WORD_W-1:0] new_ip
);
  localparam int GATE_SHIFT = $clog2(2 * WORD_BYTES);
  localparam logic [WORD_W-1:0] STEP_V = WORD_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(CTX_WORDS - 1);
  localparam logic [1:0] CPL_KERNEL = 2'd0;
  localparam logic [1:0] CPL_USER   = 2'd3;

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  ev_kind_e          kind_q;
  logic [VEC_W-1:0]  vec_q;
  logic [1:0]        cpl_q;
  logic [WORD_W-1:0] gw_target, gw_ctrl;
  logic [SEL_W-1:0]  ks_q;
  logic              fault_q, done_q;

  logic              accept, mem_fire, is_ret_req;
  gate_t             gate;
  logic              allow;
  logic [WORD_W-1:0] gate_addr;
  logic [WORD_W-1:0] sp, sp_below, sp_load_val;
  logic              sp_load, sp_dec, sp_inc;
  logic [CTX_WORDS-1:0][WORD_W-1:0] snap, ctx;
  logic              ctx_wr;
  logic              unused_seg_hi;

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign is_ret_req = (ev_kind_e'(req_kind) == EV_RETURN);
  assign busy       = (state != S_IDLE);
  assign done       = done_q;
  assign fault      = done_q && fault_q;

  // gate decode and privilege decision
  trap_gate_dec u_gate (
    .w_target (gw_target),
    .w_ctrl   (gw_ctrl),
    .kind     (kind_q),
    .cpl      (cpl_q),
    .gate     (gate),
    .allow    (allow)
  );

  // stack pointer: kernel stack on entry, user stack on return
  assign sp_load     = (accept && is_ret_req) || (state == S_CHK && allow);
  assign sp_load_val = (state == S_IDLE) ? cur_sp : tss_sp;
  assign sp_dec      = (state == S_PSH) && mem_fire;
  assign sp_inc      = (state == S_PWT) && mem_rvalid;

  trap_sp_unit #(.W(WORD_W), .STEP(WORD_BYTES)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sp_load),
    .load_val (sp_load_val),
    .dec      (sp_dec),
    .inc      (sp_inc),
    .sp       (sp),
    .sp_below (sp_below)
  );

  // context words, captured at acceptance, refilled by pops
  always_comb begin
    snap         = '0;
    snap[CTX_SS] = WORD_W'(cur_ss);
    snap[CTX_SP] = cur_sp;
    snap[CTX_FL] = cur_flags;
    snap[CTX_CS] = WORD_W'(cur_cs);
    snap[CTX_IP] = cur_ip;
  end

  assign ctx_wr = (state == S_PWT) && mem_rvalid;

  trap_ctx_file #(.N(CTX_WORDS), .W(WORD_W)) u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap_we (accept),
    .snap    (snap),
    .wr_en   (ctx_wr),
    .wr_idx  (cnt),
    .wr_data (mem_rdata),
    .q       (ctx)
  );

  // memory command
  assign gate_addr = idt_base + (WORD_W'(vec_q) << GATE_SHIFT)
                   + ((cnt == '0) ? '0 : STEP_V);

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    unique case (state)
      S_GRD: begin
        mem_valid = 1'b1;
        mem_addr  = gate_addr;
      end
      S_PSH: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_below;
        mem_wdata = ctx[cnt];
      end
      S_POP: mem_valid = 1'b1;
      default: ;
    endcase
  end

  assign mem_fire = mem_valid && mem_ready;

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      kind_q    <= EV_SOFT;
      vec_q     <= '0;
      cpl_q     <= '0;
      gw_target <= '0;
      gw_ctrl   <= '0;
      ks_q      <= '0;
      fault_q   <= 1'b0;
      done_q    <= 1'b0;
      new_cpl   <= CPL_KERNEL;
      new_ss    <= '0;
      new_sp    <= '0;
      new_flags <= '0;
      new_cs    <= '0;
      new_ip    <= '0;
    end else begin
      done_q <= (state == S_LOAD);
      unique case (state)
        S_IDLE: if (accept) begin
          kind_q  <= ev_kind_e'(req_kind);
          vec_q   <= req_vec;
          cpl_q   <= cur_cpl;
          fault_q <= 1'b0;
          if (is_ret_req) begin
            cnt   <= LAST;
            state <= S_POP;
          end else begin
            cnt   <= '0;
            state <= S_GRD;
          end
        end
        S_GRD: if (mem_ready) state <= S_GWT;
        S_GWT: if (mem_rvalid) begin
          if (cnt == '0) begin
            gw_target <= mem_rdata;
            cnt       <= CNT_W'(1);
            state     <= S_GRD;
          end else begin
            gw_ctrl <= mem_rdata;
            state   <= S_CHK;
          end
        end
        S_CHK: begin
          ks_q <= tss_ss;
          cnt  <= '0;
          if (!allow) begin
            fault_q <= 1'b1;
            state   <= S_LOAD;
          end else begin
            state <= S_PSH;
          end
        end
        S_PSH: if (mem_ready) begin
          if (cnt == LAST) state <= S_LOAD;
          else             cnt   <= cnt + CNT_W'(1);
        end
        S_POP: if (mem_ready) state <= S_PWT;
        S_PWT: if (mem_rvalid) begin
          if (cnt == '0) state <= S_LOAD;
          else begin
            cnt   <= cnt - CNT_W'(1);
            state <= S_POP;
          end
        end
        S_LOAD: begin
          if (!fault_q) begin
            if (kind_q == EV_RETURN) begin
              new_cpl   <= CPL_USER;
              new_ss    <= ctx[CTX_SS][SEL_W-1:0];
              new_sp    <= ctx[CTX_SP];
              new_flags <= ctx[CTX_FL];
              new_cs    <= ctx[CTX_CS][SEL_W-1:0];
              new_ip    <= ctx[CTX_IP];
            end else begin
              new_cpl   <= CPL_KERNEL;
              new_ss    <= ks_q;
              new_sp    <= sp;
              new_flags <= ctx[CTX_FL] & ~(WORD_W'(gate.clr_ie) << IE_BIT);
              new_cs    <= gate.sel;
              new_ip    <= gate.target;
            end
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign unused_seg_hi = ^{ctx[CTX_SS][WORD_W-1:SEL_W], ctx[CTX_CS][WORD_W-1:SEL_W]};
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [1:0]  new_cpl,
  input logic [31:0] new_sp,
  input logic [31:0] new_ip
);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));
  // R9
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
  // R4
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> ($stable(new_ip) && $stable(new_sp) && $stable(new_cpl)));
  // R4
  fault_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
  // R6
  level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (new_cpl == 2'd0 || new_cpl == 2'd3));
endmodule

bind trap_seq trap_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .new_cpl   (new_cpl),
  .new_sp    (new_sp),
  .new_ip    (new_ip)
);

// File: tb/tb_trap_seq.sv
module tb_trap_seq;
  localparam logic [31:0] IDT    = 32'h0000_0100;
  localparam logic [31:0] KSP    = 32'h0000_0800;
  localparam logic [15:0] KSS    = 16'h0010;
  localparam logic [31:0] MARKER = 32'hDEAD_BEEF;

  // {kind, vector, cpl, present, dpl, clears IE, expect fault, pad}
  localparam logic [15:0] TAB [8] = '{
    {2'd0, 5'd3,  2'd3, 1'b1, 2'd3, 1'b1, 1'b0, 2'd0},
    {2'd0, 5'd4,  2'd3, 1'b1, 2'd0, 1'b0, 1'b1, 2'd0},
    {2'd0, 5'd5,  2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0},
    {2'd1, 5'd14, 2'd3, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0},
    {2'd2, 5'd20, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0},
    {2'd2, 5'd21, 2'd3, 1'b0, 2'd3, 1'b1, 1'b1, 2'd0},
    {2'd0, 5'd31, 2'd3, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0},
    {2'd0, 5'd0,  2'd2, 1'b1, 2'd3, 1'b1, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready;
  logic [1:0]  req_kind, cur_cpl;
  logic [4:0]  req_vec;
  logic [15:0] cur_ss, cur_cs, tss_ss;
  logic [31:0] cur_sp, cur_flags, cur_ip, idt_base, tss_sp;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, fault;
  logic [1:0]  new_cpl;
  logic [15:0] new_ss, new_cs;
  logic [31:0] new_sp, new_flags, new_ip;

  trap_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_vec(req_vec), .cur_cpl(cur_cpl), .cur_ss(cur_ss),
    .cur_sp(cur_sp), .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip),
    .idt_base(idt_base), .tss_ss(tss_ss), .tss_sp(tss_sp),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
    .new_cpl(new_cpl), .new_ss(new_ss), .new_sp(new_sp), .new_flags(new_flags),
    .new_cs(new_cs), .new_ip(new_ip)
  );

  // memory model
  logic        stall_en = 1'b0;
  logic [1:0]  stall_cnt = 2'd0;
  logic        log_clr = 1'b0;
  logic [31:0] g_addr = 32'h0, g_w0 = 32'h0, g_w1 = 32'h0, p_base = 32'h0;
  logic [31:0] p_words [5];
  logic [31:0] wlog_a [8];
  logic [31:0] wlog_d [8];
  int          wcnt = 0;
  int          n_chk = 0, n_err = 0;

  always @(negedge clk) stall_cnt <= stall_cnt + 2'd1;
  assign mem_ready = !stall_en || (stall_cnt == 2'd3);

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    if (a == g_addr)                                return g_w0;
    if (a == g_addr + 32'd4)                        return g_w1;
    if (a >= p_base && a < p_base + 32'd20)         return p_words[(a - p_base) >> 2];
    return MARKER;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_valid && mem_ready && !mem_we;
    mem_rdata  <= model_rd(mem_addr);
    if (log_clr) wcnt <= 0;
    else if (mem_valid && mem_ready && mem_we && wcnt < 8) begin
      wlog_a[wcnt] <= mem_addr;
      wlog_d[wcnt] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [4:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_vec = v;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "busy after accept", {31'b0, busy}, 32'd1);
    chk("R1", "ready while busy", {31'b0, req_ready}, 32'd0);
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 done missing: actual 0 expected 1");
    end else begin
      chk("R1", "busy low at done", {31'b0, busy}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_vec = 5'd0;
    cur_cpl = 2'd3; cur_ss = 16'h0023; cur_cs = 16'h001B;
    cur_sp = 32'h0; cur_flags = 32'h0; cur_ip = 32'h0;
    idt_base = IDT; tss_ss = KSS; tss_sp = KSP;
    for (int j = 0; j < 5; j++) p_words[j] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "busy", {31'b0, busy}, 32'd0);
    chk("R10", "done", {31'b0, done}, 32'd0);
    chk("R10", "fault", {31'b0, fault}, 32'd0);
    chk("R10", "mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R10", "req_ready", {31'b0, req_ready}, 32'd1);
    chk("R10", "new_cpl", {30'b0, new_cpl}, 32'd0);
    chk("R10", "new_sp", new_sp, 32'd0);
    chk("R10", "new_ip", new_ip, 32'd0);

    // table of entry vectors
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      logic [1:0]  k, cpl, dpl;
      logic [4:0]  v;
      logic        pr, ig, ef;
      logic [31:0] fl, p_ip, p_sp, p_fl;
      logic [1:0]  p_cpl;
      logic [15:0] p_ss, p_cs, sel;
      string       rq;
      e = TAB[i];
      k = e[15:14]; v = e[13:9]; cpl = e[8:7]; pr = e[6];
      dpl = e[5:4]; ig = e[3]; ef = e[2];
      rq = (k == 2'd0) ? (ef ? "R3" : "R5") : (ef ? "R4" : "R7");
      sel = 16'h0008 + 16'(v);
      g_addr = IDT + 32'(v) * 32'd8;
      g_w0   = 32'h0010_0000 + 32'(v) * 32'h40;
      g_w1   = {12'h0, ig, dpl, pr, sel};
      cur_cpl = cpl;
      cur_sp = 32'h7FF0 - 32'(i) * 32'h10;
      fl = 32'h0000_0202 | (32'(i) << 12);
      cur_flags = fl;
      cur_ip = 32'h0040_0000 + 32'(i) * 32'd4;
      stall_en = i[0];
      p_cpl = new_cpl; p_ss = new_ss; p_sp = new_sp;
      p_fl = new_flags; p_cs = new_cs; p_ip = new_ip;
      clear_log();
      issue(k, v);
      wait_done();
      chk(rq, "fault flag", {31'b0, fault}, {31'b0, ef});
      if (ef) begin
        // R4: no writes, state kept
        chk("R4", "write count", 32'(wcnt), 32'd0);
        chk("R4", "new_ip kept", new_ip, p_ip);
        chk("R4", "new_sp kept", new_sp, p_sp);
        chk("R4", "new_cpl kept", {30'b0, new_cpl}, {30'b0, p_cpl});
        chk("R4", "other kept", {new_ss, new_cs}, {p_ss, p_cs});
        chk("R4", "flags kept", new_flags, p_fl);
      end else begin
        chk("R6", "new_cpl", {30'b0, new_cpl}, 32'd0);
        chk("R6", "new_ss", {16'b0, new_ss}, {16'b0, KSS});
        chk("R6", "new_sp", new_sp, KSP - 32'd20);
        chk("R2", "new_cs", {16'b0, new_cs}, {16'b0, sel});
        chk("R2", "new_ip", new_ip, g_w0);
        chk("R6", "new_flags", new_flags, ig ? (fl & ~32'h200) : fl);
        chk("R5", "write count", 32'(wcnt), 32'd5);
        for (int j = 0; j < 5; j++)
          chk("R5", "push address", wlog_a[j], KSP - 32'd4 * 32'(j + 1));
        chk("R5", "push SS", wlog_d[0], 32'h0000_0023);
        chk("R5", "push SP", wlog_d[1], cur_sp);
        chk("R5", "push flags", wlog_d[2], fl);
        chk("R5", "push CS", wlog_d[3], 32'h0000_001B);
        chk("R5", "push IP", wlog_d[4], cur_ip);
      end
    end

    // R8: return pops IP, CS, flags, SP, SS from ascending addresses
    for (int r = 0; r < 2; r++) begin
      p_base = 32'h0000_0200 + 32'(r) * 32'h40;
      p_words[0] = 32'h0040_1234 + 32'(r);
      p_words[1] = 32'h0000_001B;
      p_words[2] = 32'h0000_0202 + 32'(r) * 32'h100;
      p_words[3] = 32'h0000_7F00 - 32'(r) * 32'h10;
      p_words[4] = 32'h0000_0023;
      cur_sp = p_base;
      cur_cpl = 2'd0;
      stall_en = (r == 1);
      clear_log();
      issue(2'd3, 5'd9);
      wait_done();
      chk("R8", "fault", {31'b0, fault}, 32'd0);
      chk("R8", "write count", 32'(wcnt), 32'd0);
      chk("R8", "new_cpl", {30'b0, new_cpl}, 32'd3);
      chk("R8", "new_ip", new_ip, p_words[0]);
      chk("R8", "new_cs", {16'b0, new_cs}, p_words[1]);
      chk("R8", "new_flags", new_flags, p_words[2]);
      chk("R8", "new_sp", new_sp, p_words[3]);
      chk("R8", "new_ss", {16'b0, new_ss}, p_words[4]);
    end

    // R1: back to ready, done gone one cycle later
    @(negedge clk);
    chk("R1", "done one cycle", {31'b0, done}, 32'd0);
    chk("R1", "ready when idle", {31'b0, req_ready}, 32'd1);
    chk("R9", "no command idle", {31'b0, mem_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule